// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is a single channel of a DMA engine that moves data between memory and a device. Transfers are described by four-word descriptors. Each descriptor holds a device address, a memory address, a size word and a next word. The size word carries an element width and an element count. The next word carries a link to the following descriptor and a two-bit control code.

The channel runs in one of two modes. In direct mode it copies one descriptor from its register inputs and runs it. In chained mode it takes only a start pointer from the next-word register. It then reads descriptors from memory over its own request/acknowledge port and walks the linked list.

Every element is moved as a read beat followed by a write beat on the same port. The device address stays fixed for the whole descriptor. The memory address advances by the element width after each element. A registered interrupt pulse marks a descriptor that asked for notification. An error pulse, which always comes together with the interrupt pulse, marks a descriptor that was rejected. A two-bit phase output tells software where the channel is.

Top module: `dmaeng_channel`

## Requirements
- R1: After a synchronous active-low reset the phase is 0, no memory request is raised, and both the interrupt pulse and the error pulse are low.
- R2: In chained mode each descriptor is fetched as four word reads (size code 2) at pointer+0x0, +0x4, +0x8 and +0xC. These carry the device address, the memory address, the size word and the next word, in that order, and all four are issued while the phase is 1.
- R3: Size-word bits 13:12 select the element width, and the memory address advances by that width per element. Code 3 gives 1 byte (transfer size output 0, step 1). Code 2 gives 2 bytes (size 1, step 2). Code 0 gives 4 bytes (size 2, step 4). Bits 11:0 hold the element count.
- R4: A descriptor is rejected in any of these cases: its width code is 1, its count is 0, its count exceeds 0x3FF for the 1-byte or 2-byte widths, or its count exceeds 0x7FF for the 4-byte width. On rejection the channel makes no data access, pulses the error and interrupt outputs in the same cycle, returns to idle and does not follow the chain.
- R5: When the last element of a descriptor completes, the interrupt output pulses once if bit 0 of its next word is 1. In chained mode, if bit 1 is 1, the channel then fetches the descriptor at next-word bits 31:2 times 4.
- R6: In direct mode the channel reads no descriptor from memory. It uses the four register inputs sampled at the start, and it ends after that one descriptor even when bit 1 of the next word is set.
- R7: In chained mode the first fetch address is the next-word register with its two low bits forced to 0.
- R8: The phase output is 0 when idle, 1 while reading a descriptor, 2 in the single check cycle that follows a descriptor load, and 3 during element reads and writes.
- R9: A start strobe is honoured only while the phase is 0. A strobe during a transfer changes no access and no pulse.
- R10: With the direction input at 1 (sampled at start), each element is read from the current memory address and written to the device address. With the direction input at 0, each element is read from the device address and written to the current memory address. The written data equals the data just read.
- R11: Once raised, a memory request keeps its address, write flag and write data until the cycle in which it is acknowledged, and each acknowledge completes exactly one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, honoured only when idle |
| mode_sg | input | 1 | 1 selects chained mode, 0 selects direct mode |
| dir_to_dev | input | 1 | 1 moves data from memory to the device, 0 moves data from the device to memory |
| reg_dev_addr | input | 32 | Device address register |
| reg_mem_addr | input | 32 | Memory address register |
| reg_size | input | CNT_W+2 | Size register: width code in the top two bits, count below it |
| reg_next | input | 32 | Next word register: link in bits 31:2, control code in bits 1:0 |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for a write beat |
| mem_addr | output | 32 | Byte address of the beat |
| mem_size | output | 2 | Beat size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Acknowledge; completes the current beat |
| mem_rdata | input | 32 | Read data, valid with the acknowledge |
| phase | output | 2 | Channel phase code |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| err_pulse | output | 1 | One-cycle rejection pulse |

## Verification
The hardest case to reach from the ports is a chain that breaks in the middle. The channel must first finish a good descriptor and raise its interrupt. It must then fetch a bad one, reject it and never fetch the link that the bad one carries. The bench places a descriptor table in its memory model in which a valid first entry points at a descriptor with the reserved width code, and that entry links onward to a valid third. The bench then checks the exact beat sequence and both pulse counts. A start strobe during a slow-acknowledge transfer is the other hard case, and the bench reaches it by stretching every acknowledge.

// File: rtl/dmaeng_pkg.sv
// Shared types and codes for the linked-descriptor DMA channel.
// Assumes 32-bit descriptor words and a 2-bit width code directly above the count.
package dmaeng_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_RD,
        ST_WR
    } dmaeng_state_e;

    localparam logic [1:0] PH_IDLE  = 2'd0;
    localparam logic [1:0] PH_DESC  = 2'd1;
    localparam logic [1:0] PH_WAIT  = 2'd2;
    localparam logic [1:0] PH_DATA  = 2'd3;

    localparam logic [1:0] WC_BYTE  = 2'd3;
    localparam logic [1:0] WC_HALF  = 2'd2;
    localparam logic [1:0] WC_WORD  = 2'd0;

    localparam logic [1:0] LANE_1   = 2'd0;
    localparam logic [1:0] LANE_2   = 2'd1;
    localparam logic [1:0] LANE_4   = 2'd2;

    localparam logic [1:0] LAST_WORD_IDX = 2'd3;
endpackage

// File: rtl/dmaeng_desc_check.sv
// Decodes and validates a descriptor size word.
// Assumes the width code sits in the two bits directly above a CNT_W-bit count.
module dmaeng_desc_check
    import dmaeng_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int MAX_NARROW = 'h3FF,
    parameter int MAX_WIDE   = 'h7FF
) (
    input  logic [CNT_W+1:0] size_w,
    output logic             ok,
    output logic [CNT_W-1:0] cnt,
    output logic [2:0]       step,
    output logic [1:0]       lane
);
    logic [1:0]       code;
    logic [CNT_W-1:0] lim;
    logic             code_ok;

    // Map the width code to byte step, beat size and count limit.
    always_comb begin
        code    = size_w[CNT_W+1:CNT_W];
        cnt     = size_w[CNT_W-1:0];
        code_ok = 1'b1;
        unique case (code)
            WC_BYTE: begin step = 3'd1; lane = LANE_1; lim = CNT_W'(MAX_NARROW); end
            WC_HALF: begin step = 3'd2; lane = LANE_2; lim = CNT_W'(MAX_NARROW); end
            WC_WORD: begin step = 3'd4; lane = LANE_4; lim = CNT_W'(MAX_WIDE);   end
            default: begin step = 3'd4; lane = LANE_4; lim = '0; code_ok = 1'b0; end
        endcase
        ok = code_ok && (cnt != '0) && (cnt <= lim);
    end
endmodule

// File: rtl/dmaeng_desc_store.sv
// Holds the active descriptor; loaded whole from registers or word by word from memory.
// Assumes word index 0..3 maps to device, memory, size, next.
module dmaeng_desc_store #(
    parameter int SZ_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [31:0]     ld_dev,
    input  logic [31:0]     ld_mem,
    input  logic [SZ_W-1:0] ld_size,
    input  logic [31:0]     ld_next,
    input  logic            wr,
    input  logic [1:0]      wr_idx,
    input  logic [31:0]     wr_word,
    output logic [31:0]     dev,
    output logic [31:0]     mem,
    output logic [SZ_W-1:0] size,
    output logic [31:0]     nxt
);
    // Capture register copy on a direct start, or one fetched word per acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev  <= '0;
            mem  <= '0;
            size <= '0;
            nxt  <= '0;
        end else if (load) begin
            dev  <= ld_dev;
            mem  <= ld_mem;
            size <= ld_size;
            nxt  <= ld_next;
        end else if (wr) begin
            unique case (wr_idx)
                2'd0: dev  <= wr_word;
                2'd1: mem  <= wr_word;
                2'd2: size <= wr_word[SZ_W-1:0];
                default: nxt <= wr_word;
            endcase
        end
    end
endmodule

// File: rtl/dmaeng_walker.sv
// Element counter and advancing memory pointer for one descriptor.
// Assumes load and adv are never asserted together.
module dmaeng_walker #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic [31:0]      base_in,
    input  logic [2:0]       step,
    input  logic             adv,
    output logic [31:0]      cur,
    output logic             last
);
    logic [CNT_W-1:0] remain;

    // Track remaining elements and the current memory byte address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            cur    <= '0;
        end else if (load) begin
            remain <= cnt_in;
            cur    <= base_in;
        end else if (adv) begin
            remain <= remain - CNT_W'(1);
            cur    <= cur + {29'd0, step};
        end
    end

    assign last = (remain == CNT_W'(1));
endmodule

// File: rtl/dmaeng_channel.sv
// One DMA channel: direct or linked-descriptor transfers over a req/ack memory port.
// Assumes mem_ack is only raised while mem_req is high; one element = read beat + write beat.
module dmaeng_channel
    import dmaeng_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int MAX_NARROW = 'h3FF,
    parameter int MAX_WIDE   = 'h7FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode_sg,
    input  logic             dir_to_dev,
    input  logic [31:0]      reg_dev_addr,
    input  logic [31:0]      reg_mem_addr,
    input  logic [CNT_W+1:0] reg_size,
    input  logic [31:0]      reg_next,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [1:0]       mem_size,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic [1:0]       phase,
    output logic             irq_pulse,
    output logic             err_pulse
);
    localparam int SZ_W = CNT_W + 2;

    dmaeng_state_e    state;
    logic [1:0]       widx;
    logic [31:2]      fptr;
    logic [31:0]      hold;
    logic             dir_q;
    logic             sg_q;

    logic [31:0]      d_dev, d_mem, d_next;
    logic [SZ_W-1:0]  d_size;
    logic             chk_ok;
    logic [CNT_W-1:0] chk_cnt;
    logic [2:0]       chk_step;
    logic [1:0]       chk_lane;
    logic [31:0]      w_cur;
    logic             w_last;

    logic             store_load, store_wr, walk_load, walk_adv;

    // Strobes for the sub-blocks, derived from the current state.
    always_comb begin
        store_load = (state == ST_IDLE) && start && !mode_sg;
        store_wr   = (state == ST_FETCH) && mem_ack;
        walk_load  = (state == ST_CHECK) && chk_ok;
        walk_adv   = (state == ST_WR) && mem_ack;
    end

    dmaeng_desc_store #(.SZ_W(SZ_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (store_load),
        .ld_dev  (reg_dev_addr),
        .ld_mem  (reg_mem_addr),
        .ld_size (reg_size),
        .ld_next (reg_next),
        .wr      (store_wr),
        .wr_idx  (widx),
        .wr_word (mem_rdata),
        .dev     (d_dev),
        .mem     (d_mem),
        .size    (d_size),
        .nxt     (d_next)
    );

    dmaeng_desc_check #(
        .CNT_W      (CNT_W),
        .MAX_NARROW (MAX_NARROW),
        .MAX_WIDE   (MAX_WIDE)
    ) u_check (
        .size_w (d_size),
        .ok     (chk_ok),
        .cnt    (chk_cnt),
        .step   (chk_step),
        .lane   (chk_lane)
    );

    dmaeng_walker #(.CNT_W(CNT_W)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (walk_load),
        .cnt_in  (chk_cnt),
        .base_in (d_mem),
        .step    (chk_step),
        .adv     (walk_adv),
        .cur     (w_cur),
        .last    (w_last)
    );

    // Sequencer: start, descriptor fetch, check, element read/write, chain follow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            widx      <= '0;
            fptr      <= '0;
            hold      <= '0;
            dir_q     <= 1'b0;
            sg_q      <= 1'b0;
            irq_pulse <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            irq_pulse <= 1'b0;
            err_pulse <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        dir_q <= dir_to_dev;
                        sg_q  <= mode_sg;
                        widx  <= '0;
                        fptr  <= reg_next[31:2];
                        state <= mode_sg ? ST_FETCH : ST_CHECK;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        widx <= widx + 2'd1;
                        if (widx == LAST_WORD_IDX) state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!chk_ok) begin
                        err_pulse <= 1'b1;
                        irq_pulse <= 1'b1;
                        state     <= ST_IDLE;
                    end else begin
                        state <= ST_RD;
                    end
                end
                ST_RD: begin
                    if (mem_ack) begin
                        hold  <= mem_rdata;
                        state <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (mem_ack) begin
                        if (w_last) begin
                            irq_pulse <= d_next[0];
                            if (sg_q && d_next[1]) begin
                                fptr  <= d_next[31:2];
                                widx  <= '0;
                                state <= ST_FETCH;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            state <= ST_RD;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory port drive: address source depends on state and latched direction.
    always_comb begin
        mem_req   = (state == ST_FETCH) || (state == ST_RD) || (state == ST_WR);
        mem_we    = (state == ST_WR);
        mem_wdata = hold;
        mem_size  = (state == ST_FETCH) ? LANE_4 : chk_lane;
        unique case (state)
            ST_FETCH: mem_addr = {fptr + {28'd0, widx}, 2'b00};
            ST_RD:    mem_addr = dir_q ? w_cur : d_dev;
            ST_WR:    mem_addr = dir_q ? d_dev : w_cur;
            default:  mem_addr = '0;
        endcase
    end

    // Phase code reported to software.
    always_comb begin
        unique case (state)
            ST_FETCH: phase = PH_DESC;
            ST_CHECK: phase = PH_WAIT;
            ST_RD,
            ST_WR:    phase = PH_DATA;
            default:  phase = PH_IDLE;
        endcase
    end
endmodule

// File: rtl/dmaeng_channel_chk.sv
// Protocol checker for dmaeng_channel, attached by bind.
// Assumes the same reset polarity as the channel.
module dmaeng_channel_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [1:0]  phase,
    input logic        mem_req,
    input logic        mem_ack,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        irq_pulse,
    input logic        err_pulse
);
    p_idle_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0) |-> !mem_req);

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_err_with_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (irq_pulse && phase == 2'd0));

    p_desc_phase_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1) |-> (mem_req && !mem_we));

    p_idle_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0 && !start) |=> (phase == 2'd0));

    p_write_in_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (phase == 2'd3));
endmodule

bind dmaeng_channel dmaeng_channel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .phase     (phase),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .irq_pulse (irq_pulse),
    .err_pulse (err_pulse)
);

// File: tb/dmaeng_channel_test.sv
`timescale 1ns/1ps
module dmaeng_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, mode_sg = 1'b0, dir_to_dev = 1'b0;
    logic [31:0] reg_dev_addr = '0, reg_mem_addr = '0, reg_next = '0;
    logic [13:0] reg_size = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size, phase;
    logic        irq_pulse, err_pulse;

    always #2.5 clk = ~clk;

    dmaeng_channel uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_sg(mode_sg), .dir_to_dev(dir_to_dev),
        .reg_dev_addr(reg_dev_addr), .reg_mem_addr(reg_mem_addr), .reg_size(reg_size),
        .reg_next(reg_next), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .phase(phase), .irq_pulse(irq_pulse), .err_pulse(err_pulse)
    );

    // Memory model: descriptor table below 0x100, computed pattern elsewhere.
    logic [31:0] dmem [0:63];
    function automatic logic [31:0] rd_val(input logic [31:0] a);
        if (a < 32'h100) return dmem[a[7:2]];
        return a ^ 32'hC3C3_0000;
    endfunction

    int lat = 0;
    int wc;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; wc <= 0; mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            if (wc >= lat) begin
                mem_ack <= 1'b1; mem_rdata <= rd_val(mem_addr); wc <= 0;
            end else wc <= wc + 1;
        end else mem_ack <= 1'b0;
    end

    // Expected beat list and monitor state.
    logic        e_we [0:63];
    logic [31:0] e_addr [0:63];
    logic [31:0] e_data [0:63];
    logic [1:0]  e_sz [0:63];
    logic [1:0]  e_ph [0:63];
    int exp_n = 0, base_log = 0, mm_base = 0;
    bit detail = 1'b1;
    int nlog = 0, mm = 0, n_irq = 0, n_err = 0, viol = 0;
    logic [31:0] last_addr = '0, fa_act = '0, fa_exp = '0;
    logic        pw = 1'b0, pwe = 1'b0;
    logic [31:0] pa = '0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (irq_pulse) n_irq++;
            if (err_pulse) n_err++;
            if (pw && (!mem_req || mem_addr != pa || mem_we != pwe)) viol++;
            pw = mem_req && !mem_ack; pa = mem_addr; pwe = mem_we;
            if (mem_req && mem_ack) begin
                if (detail) begin
                    automatic int k = nlog - base_log;
                    if (k >= exp_n || k > 63 || mem_we != e_we[k] || mem_addr != e_addr[k] ||
                        mem_size != e_sz[k] || phase != e_ph[k] ||
                        (mem_we && mem_wdata != e_data[k])) begin
                        if (mm == mm_base) begin
                            fa_act = mem_addr;
                            fa_exp = (k < exp_n && k < 64) ? e_addr[k] : 32'hFFFF_FFFF;
                        end
                        mm++;
                    end
                end
                last_addr = mem_addr;
                nlog++;
            end
        end
    end

    int n_chk = 0, n_fail = 0;
    int irq0, err0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic we, input logic [31:0] a, input logic [31:0] d,
                        input logic [1:0] sz, input logic [1:0] ph);
        if (exp_n < 64) begin
            e_we[exp_n] = we; e_addr[exp_n] = a; e_data[exp_n] = d;
            e_sz[exp_n] = sz; e_ph[exp_n] = ph;
        end
        exp_n++;
    endtask

    task automatic push_fetch(input logic [31:0] p);
        for (int k = 0; k < 4; k++) push(1'b0, p + 32'(4 * k), '0, 2'd2, 2'd1);
    endtask

    task automatic push_desc(input logic [31:0] dv, input logic [31:0] mv,
                             input logic [13:0] sz, input bit dir);
        automatic int step = (sz[13:12] == 2'd3) ? 1 : (sz[13:12] == 2'd2) ? 2 : 4;
        automatic logic [1:0] ls = (step == 1) ? 2'd0 : (step == 2) ? 2'd1 : 2'd2;
        for (int i = 0; i < int'(sz[11:0]); i++) begin
            automatic logic [31:0] ma = mv + 32'(i * step);
            automatic logic [31:0] src = dir ? ma : dv;
            automatic logic [31:0] dst = dir ? dv : ma;
            push(1'b0, src, '0, ls, 2'd3);
            push(1'b1, dst, rd_val(src), ls, 2'd3);
        end
    endtask

    task automatic begin_run(input bit det);
        base_log = nlog; mm_base = mm; exp_n = 0; irq0 = n_irq; err0 = n_err; detail = det;
    endtask

    task automatic kick(input bit sg, input bit dir, input logic [31:0] dv,
                        input logic [31:0] mv, input logic [13:0] sz, input logic [31:0] nx);
        @(negedge clk);
        start = 1'b1; mode_sg = sg; dir_to_dev = dir;
        reg_dev_addr = dv; reg_mem_addr = mv; reg_size = sz; reg_next = nx;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (phase != 2'd0 && t < 30000) begin @(negedge clk); t++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic end_run(input string rt, input string ri, input int irq_exp, input int err_exp);
        check(nlog - base_log == exp_n, rt, "beat count", nlog - base_log, exp_n);
        check(mm == mm_base, rt, "beat content", fa_act, fa_exp);
        check(n_irq - irq0 == irq_exp, ri, "interrupt pulses", n_irq - irq0, irq_exp);
        check(n_err - err0 == err_exp, "R4", "error pulses", n_err - err0, err_exp);
    endtask

    initial begin
        #1000000;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) dmem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        check(phase == 2'd0, "R1", "phase", phase, 0);
        check(!mem_req, "R1", "request", mem_req, 0);
        check(!irq_pulse && !err_pulse, "R1", "pulses", {irq_pulse, err_pulse}, 0);

        // Direct-mode sweep over width, direction, count and control code
        for (int c = 0; c < 3; c++)
            for (int d = 0; d < 2; d++)
                for (int n = 1; n <= 3; n++) begin
                    automatic logic [1:0] code = (c == 0) ? 2'd3 : (c == 1) ? 2'd2 : 2'd0;
                    automatic logic [1:0] nc = 2'((c * 6 + d * 3 + n) % 4);
                    automatic logic [31:0] dv = 32'h0000_8000 + 32'(c * 'h100);
                    automatic logic [31:0] mv = 32'h0001_0000 + 32'(d * 'h1000 + n * 'h40);
                    automatic logic [13:0] sz = {code, 12'(n)};
                    automatic string rt = nc[1] ? "R6" : (d != 0 ? "R10" : "R3");
                    lat = n % 3;
                    begin_run(1'b1);
                    push_desc(dv, mv, sz, d[0]);
                    kick(1'b0, d[0], dv, mv, sz, 32'h0000_0040 | {30'd0, nc});
                    wait_idle();
                    end_run(rt, "R5", int'(nc[0]), 0);
                end

        // Count limits: largest legal counts, then rejected descriptors
        lat = 0;
        begin_run(1'b0);
        kick(1'b0, 1'b0, 32'h8000, 32'h0002_0000, {2'd3, 12'h3FF}, 32'h1);
        wait_idle();
        check(nlog - base_log == 2 * 'h3FF, "R4", "1-byte max beats", nlog - base_log, 2 * 'h3FF);
        check(last_addr == 32'h0002_0000 + 'h3FE, "R3", "1-byte last address", last_addr, 32'h0002_03FE);
        begin_run(1'b0);
        kick(1'b0, 1'b0, 32'h8000, 32'h0003_0000, {2'd2, 12'h3FF}, 32'h1);
        wait_idle();
        check(nlog - base_log == 2 * 'h3FF, "R4", "2-byte max beats", nlog - base_log, 2 * 'h3FF);
        check(last_addr == 32'h0003_0000 + 2 * 'h3FE, "R3", "2-byte last address", last_addr, 32'h0003_07FC);
        begin_run(1'b0);
        kick(1'b0, 1'b0, 32'h8000, 32'h0004_0000, {2'd0, 12'h7FF}, 32'h1);
        wait_idle();
        check(nlog - base_log == 2 * 'h7FF, "R4", "4-byte max beats", nlog - base_log, 2 * 'h7FF);
        check(last_addr == 32'h0004_0000 + 4 * 'h7FE, "R3", "4-byte last address", last_addr, 32'h0004_1FF8);
        check(n_irq - irq0 == 1, "R5", "interrupt after max run", n_irq - irq0, 1);

        for (int b = 0; b < 5; b++) begin
            automatic logic [13:0] bad = (b == 0) ? {2'd3, 12'h400} :
                                         (b == 1) ? {2'd2, 12'h400} :
                                         (b == 2) ? {2'd0, 12'h800} :
                                         (b == 3) ? {2'd0, 12'h000} : {2'd1, 12'h005};
            begin_run(1'b1);
            kick(1'b0, 1'b1, 32'h8000, 32'h0005_0000, bad, 32'h0000_0043);
            wait_idle();
            end_run("R4", "R4", 1, 1);
        end

        // Chained mode: three descriptors, memory to device
        dmem[16] = 32'h0000_2000; dmem[17] = 32'h0000_3000;
        dmem[18] = {18'd0, 2'd2, 12'd2}; dmem[19] = 32'h0000_0062;
        dmem[24] = 32'h0000_2100; dmem[25] = 32'h0000_3100;
        dmem[26] = {18'd0, 2'd0, 12'd1}; dmem[27] = 32'h0000_0083;
        dmem[32] = 32'h0000_2200; dmem[33] = 32'h0000_3200;
        dmem[34] = {18'd0, 2'd3, 12'd3}; dmem[35] = 32'h0000_00A1;
        for (int r = 0; r < 2; r++) begin
            lat = r;
            begin_run(1'b1);
            push_fetch(32'h40); push_desc(32'h2000, 32'h3000, {2'd2, 12'd2}, 1'b1);
            push_fetch(32'h60); push_desc(32'h2100, 32'h3100, {2'd0, 12'd1}, 1'b1);
            push_fetch(32'h80); push_desc(32'h2200, 32'h3200, {2'd3, 12'd3}, 1'b1);
            kick(1'b1, 1'b1, 32'hDEAD_0000, 32'hBEEF_0000, '0, (r == 0) ? 32'h40 : 32'h43);
            wait_idle();
            end_run((r == 0) ? "R2" : "R7", "R5", 2, 0);
        end

        // Chained mode with a rejected middle descriptor, device to memory
        dmem[19] = 32'h0000_00A3;
        dmem[40] = 32'h0000_2300; dmem[41] = 32'h0000_3300;
        dmem[42] = {18'd0, 2'd1, 12'd2}; dmem[43] = 32'h0000_0082;
        lat = 1;
        begin_run(1'b1);
        push_fetch(32'h40); push_desc(32'h2000, 32'h3000, {2'd2, 12'd2}, 1'b0);
        push_fetch(32'hA0);
        kick(1'b1, 1'b0, '0, '0, '0, 32'h40);
        wait_idle();
        end_run("R4", "R5", 2, 1);

        // Start strobe during a busy transfer is ignored; phases observed
        lat = 2;
        begin_run(1'b1);
        push_desc(32'h4000, 32'h5000, {2'd0, 12'd3}, 1'b1);
        kick(1'b0, 1'b1, 32'h4000, 32'h5000, {2'd0, 12'd3}, 32'h1);
        check(phase == 2'd2, "R8", "check phase", phase, 2);
        @(negedge clk);
        check(phase == 2'd3, "R8", "data phase", phase, 3);
        repeat (2) @(negedge clk);
        start = 1'b1; mode_sg = 1'b1; reg_next = 32'h40;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        end_run("R9", "R5", 1, 0);
        check(phase == 2'd0, "R8", "idle phase", phase, 0);

        check(viol == 0, "R11", "request dropped before ack", viol, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule